// File: doc/BRIEF.md
# Ethernet Controller Host Register File

This block is the host-facing register file of an Ethernet controller. It holds sixty-four 16-bit registers behind a word-wide read/write port. The register index is the host address shifted right by a fixed amount. Reads are combinational from the stored value. Writes take effect at the clock edge.

Each register applies its own write rule. The status register is cleared by writing ones to it. The configuration registers accept writes only while the controller is held in software reset. The tally counters store the inverse of what is written. Some registers drop their low bits, and a few ignore writes entirely. The command register merges new command bits into its stored value and applies the enable/disable and start/stop pairings. It implements a sticky reset bit, and any command write that omits that bit only releases the reset.

Each accepted command is exported as a one-cycle strobe vector for the transmit, receive, timer and address-filter engines. Those engines report back through one-cycle status set pulses. A single level interrupt is raised whenever an enabled status bit is set.

Top module: `nic_host_regs`

## Requirements
- R1: After hardware reset, the registers read as follows: index 0x00 (command) reads 0x0094, 0x02 reads 0x0020, 0x03 reads 0x0101, 0x13 reads 0x02F8 and 0x28 reads 0x0004. Every other index reads 0x0000. `irq` is low and `cmd_strobe` is zero.
- R2: A host write to index 0x05 (status) clears the status bits that are both written as 1 and currently set. All other status bits keep their value.
- R3: Index 0x04 (mask) stores data & 0x7FFF. Index 0x03 stores data & 0xF000. Index 0x02 stores data & 0xFFE0.
- R4: Index 0x01 stores data & 0xBFFF, and index 0x3F stores data & 0xF017. Both accept the write only while command bit 7 (reset) is set. While that bit is clear, a write to either index leaves the stored value unchanged.
- R5: Indices 0x2C, 0x2D and 0x2E store the bitwise inverse of the written data.
- R6: Indices 0x15, 0x16, 0x17 and 0x18 store the written data with bit 0 forced to 0.
- R7: Writes to indices 0x22, 0x23, 0x24, 0x28 and 0x2F are ignored.
- R8: A write to any index not named in R2 to R7 or R11 to R12 stores the data unchanged, and a later read returns it.
- R9: Each bit set in `evt_set` during a cycle is set in the status register at that cycle's edge.
- R10: If an `evt_set` bit and a host clear of the same status bit occur in the same cycle, the bit ends up set.
- R11: `irq` is 1 exactly when the mask register ANDed with the status register is nonzero. It reflects a mask write, a status write or an event from the cycle after the edge.
- R12: Command write, case 1: if command bit 7 is set and the written data has bit 7 clear, only bit 7 is cleared, and `cmd_strobe` stays zero. Command write, case 2: otherwise, data & 0x03BF is ORed into the command register, and then these rules apply in order: bit 2 clears bit 3; bit 3 clears bit 2; bit 4 clears bit 5; bit 5 clears bit 4. In case 2, `cmd_strobe` equals data & 0x03BF for exactly one cycle, aligned with the command register update.
- R13: A command write with bit 7 set is a software reset. After the R12 rules, it clears bits 9, 8, 1 and 0 and sets bits 7 and 2.
- R14: The register index is bits [IDX_SHIFT+5:IDX_SHIFT] of `host_addr`. Address bits below IDX_SHIFT do not affect which register is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write enable for this cycle |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Stored value of the addressed register |
| evt_set | input | 16 | One-cycle status set pulses from the engines |
| cmd_strobe | output | 16 | One-cycle strobe of accepted command bits |
| irq | output | 1 | Level interrupt |

## Verification
Every index is written with all-ones, an alternating pattern and a single low bit. These three patterns are enough to tell inversion, low-bit clearing, high-bit masking and ignored writes apart from plain storage. Odd host addresses are mixed in, to show that sub-index address bits are dropped.

A sweep of one-hot mask values against a fixed sparse status pattern separates a correct AND-reduction from stuck or shifted bits, and it shows that mask bit 15 is dropped. A sequence of command words exercises each pairing rule, the software reset, and the reset release on its own. Each step of the sequence is compared against an arithmetic model of the command rules, including the paired enable/disable bits written together.

// File: rtl/nic_host_regs.sv
module nic_host_regs #(
  parameter int ADDR_W    = 7,
  parameter int IDX_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [15:0]       evt_set,
  output logic [15:0]       cmd_strobe,
  output logic              irq
);
  localparam int IDX_W = 6;
  localparam int NREG  = 1 << IDX_W;
  localparam logic [15:0] CMD_MASK = 16'h03BF;

  localparam logic [IDX_W-1:0] I_CMD = 6'h00, I_CFG = 6'h01, I_RXC = 6'h02, I_TXC = 6'h03,
                               I_MSK = 6'h04, I_STS = 6'h05, I_EOB = 6'h13, I_REV = 6'h28,
                               I_CFG2 = 6'h3F;

  logic [15:0] regs [NREG];
  logic [ADDR_W-1:0] addr_sh;
  logic [IDX_W-1:0]  idx;
  logic [15:0] cmd_q, sts_q, msk_q, cfg_q;
  logic [15:0] wr_val, cmd_nxt, sts_clr;
  logic        wr_en, cmd_hold, cmd_wr, sts_wr;

  assign addr_sh    = host_addr >> IDX_SHIFT;
  assign idx        = addr_sh[IDX_W-1:0];
  assign cmd_q      = regs[I_CMD];
  assign sts_q      = regs[I_STS];
  assign msk_q      = regs[I_MSK];
  assign cfg_q      = regs[I_CFG];
  assign host_rdata = regs[idx];
  assign irq        = |(msk_q & sts_q);
  assign cmd_wr     = host_wr && (idx == I_CMD);
  assign sts_wr     = host_wr && (idx == I_STS);
  assign cmd_hold   = cmd_q[7] && !host_wdata[7];
  assign sts_clr    = sts_wr ? host_wdata : 16'h0;

  always_comb begin
    wr_en  = host_wr;
    wr_val = host_wdata;
    case (idx)
      I_CMD, I_STS:                   wr_en = 1'b0;
      I_CFG:  begin wr_en = host_wr && cmd_q[7]; wr_val = host_wdata & 16'hBFFF; end
      I_CFG2: begin wr_en = host_wr && cmd_q[7]; wr_val = host_wdata & 16'hF017; end
      I_RXC:                          wr_val = host_wdata & 16'hFFE0;
      I_TXC:                          wr_val = host_wdata & 16'hF000;
      I_MSK:                          wr_val = host_wdata & 16'h7FFF;
      6'h15, 6'h16, 6'h17, 6'h18:     wr_val = host_wdata & 16'hFFFE;
      6'h2C, 6'h2D, 6'h2E:            wr_val = ~host_wdata;
      6'h22, 6'h23, 6'h24, I_REV, 6'h2F: wr_en = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    cmd_nxt = cmd_q | (host_wdata & CMD_MASK);
    if (host_wdata[2]) cmd_nxt[3] = 1'b0;
    if (host_wdata[3]) cmd_nxt[2] = 1'b0;
    if (host_wdata[4]) cmd_nxt[5] = 1'b0;
    if (host_wdata[5]) cmd_nxt[4] = 1'b0;
    if (host_wdata[7]) cmd_nxt = (cmd_nxt & ~16'h0303) | 16'h0084;
    if (cmd_hold) cmd_nxt = cmd_q & ~16'h0080;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 16'h0;
      regs[I_CMD] <= 16'h0094;
      regs[I_RXC] <= 16'h0020;
      regs[I_TXC] <= 16'h0101;
      regs[I_EOB] <= 16'h02F8;
      regs[I_REV] <= 16'h0004;
      cmd_strobe  <= 16'h0;
    end else begin
      cmd_strobe <= 16'h0;
      if (cmd_wr) begin
        regs[I_CMD] <= cmd_nxt;
        cmd_strobe  <= cmd_hold ? 16'h0 : (host_wdata & CMD_MASK);
      end
      if (wr_en) regs[idx] <= wr_val;
      regs[I_STS] <= (sts_q & ~sts_clr) | evt_set;
    end
  end

  // R2
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && evt_set == 16'h0) |=> ((sts_q & $past(host_wdata)) == 16'h0));
  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 16'h0) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));
  // R12
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_q[7] && !host_wdata[7]) |=> (cmd_strobe == 16'h0 && cmd_q == ($past(cmd_q) & ~16'h0080)));
  // R12
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != 16'h0) |-> $past(cmd_wr));
  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && idx == I_CFG && !cmd_q[7]) |=> $stable(cfg_q));
  // R13
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_wdata[7]) |=> (cmd_q[7] && cmd_q[2] && (cmd_q & 16'h0303) == 16'h0));
endmodule

// File: tb/test_nic_host_regs.sv
module test_nic_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 7;
  localparam int SH = 1;

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [15:0] host_wdata = 16'h0, evt_set = 16'h0;
  logic [15:0] host_rdata, cmd_strobe;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mir [64];

  nic_host_regs #(.ADDR_W(ADDR_W), .IDX_SHIFT(SH)) i_nic_host_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
    .cmd_strobe(cmd_strobe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d, input bit odd);
    host_addr  = ADDR_W'((idx << SH) | (odd ? 1 : 0));
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [15:0] exp, input string req);
    host_addr = ADDR_W'(idx << SH);
    #1;
    chk(host_rdata == exp, req, host_rdata, exp);
  endtask

  function automatic logic [15:0] store_exp(input int idx, input logic [15:0] d,
                                            input logic [15:0] old, input bit in_rst);
    case (idx)
      1:  return in_rst ? (d & 16'hBFFF) : old;
      63: return in_rst ? (d & 16'hF017) : old;
      2:  return d & 16'hFFE0;
      3:  return d & 16'hF000;
      4:  return d & 16'h7FFF;
      21, 22, 23, 24: return d & 16'hFFFE;
      44, 45, 46: return ~d;
      34, 35, 36, 40, 47: return old;
      default: return d;
    endcase
  endfunction

  function automatic string req_of(input int idx);
    case (idx)
      1, 63: return "R4";
      2, 3, 4: return "R3";
      21, 22, 23, 24: return "R6";
      44, 45, 46: return "R5";
      34, 35, 36, 40, 47: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] cmd_exp(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] n;
    if (c[7] && !d[7]) return c & ~16'h0080;
    n = c | (d & 16'h03BF);
    if (d[2]) n[3] = 1'b0;
    if (d[3]) n[2] = 1'b0;
    if (d[4]) n[5] = 1'b0;
    if (d[5]) n[4] = 1'b0;
    if (d[7]) n = (n & ~16'h0303) | 16'h0084;
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [3];
    logic [15:0] sts;
    pats[0] = 16'hFFFF; pats[1] = 16'hA5A5; pats[2] = 16'h0001;
    for (int i = 0; i < 64; i++) mir[i] = 16'h0;
    mir[0] = 16'h0094; mir[2] = 16'h0020; mir[3] = 16'h0101;
    mir[19] = 16'h02F8; mir[40] = 16'h0004;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at every index
    for (int i = 0; i < 64; i++) rd_chk(i, mir[i], "R1");
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(cmd_strobe == 16'h0, "R1 strobe", cmd_strobe, 0);

    // R4 configuration writes while in reset
    wr(1, 16'hFFFF, 0); mir[1] = 16'hBFFF; rd_chk(1, mir[1], "R4");
    wr(63, 16'hFFFF, 1); mir[63] = 16'hF017; rd_chk(63, mir[63], "R4");

    // R12 reset release: only bit 7 clears, no strobe
    wr(0, 16'h0123, 0);
    chk(cmd_strobe == 16'h0, "R12 release strobe", cmd_strobe, 0);
    mir[0] = 16'h0014; rd_chk(0, mir[0], "R12 release");
    @(negedge clk);
    chk(cmd_strobe == 16'h0, "R12 strobe idle", cmd_strobe, 0);

    // R4 locked once out of reset
    wr(1, 16'h1234, 0); rd_chk(1, mir[1], "R4 locked");
    wr(63, 16'h0000, 0); rd_chk(63, mir[63], "R4 locked");

    // R3 R5 R6 R7 R8 R14 write-rule sweep over all indices
    for (int p = 0; p < 3; p++) begin
      for (int i = 1; i < 64; i++) begin
        if (i == 5) continue;
        wr(i, pats[p], pats[p][0]);
        mir[i] = store_exp(i, pats[p], mir[i], 1'b0);
        rd_chk(i, mir[i], req_of(i));
      end
    end
    for (int i = 1; i < 64; i++) if (i != 5) rd_chk(i, mir[i], "R14 no alias");

    wr(4, 16'h0000, 0); mir[4] = 16'h0;

    // R9 events set status bits
    evt_set = 16'h00F0; @(negedge clk); evt_set = 16'h0;
    rd_chk(5, 16'h00F0, "R9");
    chk(irq == 1'b0, "R11 masked", irq, 0);
    // R2 write-one-to-clear
    wr(5, 16'h0030, 0); rd_chk(5, 16'h00C0, "R2");
    wr(5, 16'h0F0F, 1); rd_chk(5, 16'h00C0, "R2 unset bits");
    // R10 event beats a same-cycle clear
    evt_set = 16'h0040; wr(5, 16'h0040, 0); evt_set = 16'h0;
    rd_chk(5, 16'h00C0, "R10");
    wr(5, 16'hFFFF, 0); rd_chk(5, 16'h0000, "R2 clear all");

    // R11 mask sweep against a sparse status pattern
    sts = 16'h8421;
    evt_set = sts; @(negedge clk); evt_set = 16'h0;
    for (int b = 0; b < 16; b++) begin
      logic [15:0] m;
      m = 16'h1 << b;
      wr(4, m, 0);
      rd_chk(4, m & 16'h7FFF, "R3 mask");
      chk(irq == |(m & 16'h7FFF & sts), "R11", irq, |(m & 16'h7FFF & sts));
    end
    wr(4, 16'h7FFF, 0);
    chk(irq == 1'b1, "R11 all", irq, 1);
    wr(5, 16'hFFFF, 0);
    chk(irq == 1'b0, "R11 after clear", irq, 0);
    evt_set = 16'h0200; @(negedge clk); evt_set = 16'h0;
    chk(irq == 1'b1, "R11 event", irq, 1);
    wr(5, 16'h0200, 0);
    chk(irq == 1'b0, "R11 cleared", irq, 0);

    // R12 R13 command sequence against the model
    begin
      logic [15:0] seq [14];
      logic [15:0] es;
      seq[0] = 16'h0008; seq[1] = 16'h0020; seq[2] = 16'h0002; seq[3] = 16'h0200;
      seq[4] = 16'h0100; seq[5] = 16'h0080; seq[6] = 16'h0002; seq[7] = 16'h0040;
      seq[8] = 16'h0004; seq[9] = 16'h000C; seq[10] = 16'h0010; seq[11] = 16'h0030;
      seq[12] = 16'h0381; seq[13] = 16'h0080;
      for (int k = 0; k < 14; k++) begin
        es = (mir[0][7] && !seq[k][7]) ? 16'h0 : (seq[k] & 16'h03BF);
        mir[0] = cmd_exp(mir[0], seq[k]);
        wr(0, seq[k], k[0]);
        chk(cmd_strobe == es, seq[k][7] ? "R13 strobe" : "R12 strobe", cmd_strobe, es);
        rd_chk(0, mir[0], seq[k][7] ? "R13" : "R12");
      end
      @(negedge clk);
      chk(cmd_strobe == 16'h0, "R12 one cycle", cmd_strobe, 0);
    end
    // R4 writable again after software reset
    wr(1, 16'h4321, 0); rd_chk(1, 16'h4321 & 16'hBFFF, "R4 reopened");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule